// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap

This block produces the access address for a synchronous memory port. Each clock cycle is either a load or an advance. A load takes a fresh external address and fixes the cycle type for the burst that follows: read, write or deselect. An advance produces the next address of the current burst from a 2-bit counter that works on the two lowest address bits. The upper bits do not change during a burst.

The burst order is set at load time from a mode input. Linear order adds the count to the base low bits modulo four. Interleaved order XORs the count into the base low bits. After four accesses the sequence comes back to the base address. Bursts are optional, so an address may be loaded on every cycle. An active-low clock enable freezes the whole sequencer. The outputs come from registers. They show the current address, the current cycle type, and whether the current cycle came from a load.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge with `clk_en_n` low and `load_n` low, the block takes `addr_in` as the base. From the next cycle on, `addr_out` equals that address exactly and `loaded` is 1. `cyc_out` becomes 2'b00 (deselect) when `sel` is 0, 2'b10 (write) when `sel` and `wr` are both 1, and 2'b01 (read) when `sel` is 1 and `wr` is 0.
- R2: On an enabled edge with `load_n` high while `cyc_out` is read or write, the burst count increments by one. `loaded` goes to 0, and `cyc_out` and `addr_out[ADDR_W-1:2]` keep their values.
- R3: In linear order (`ilv_mode` = 0 when loaded), `addr_out[1:0]` equals (base[1:0] + count) mod 4.
- R4: In interleaved order (`ilv_mode` = 1 when loaded), `addr_out[1:0]` equals base[1:0] XOR count.
- R5: After four advances from a load, `addr_out` equals the loaded base address again.
- R6: The order is captured with the load. Changing `ilv_mode` during advances has no effect on the addresses of the running burst.
- R7: While `clk_en_n` is high, all inputs are ignored and `addr_out`, `cyc_out` and `loaded` hold their values.
- R8: An advance while `cyc_out` is deselect leaves `cyc_out` at deselect and `addr_out` unchanged, and sets `loaded` to 0.
- R9: After a synchronous reset (`rst_n` low at a rising edge), `addr_out` is 0, `cyc_out` is deselect and `loaded` is 0.
- R10: Loads on back-to-back cycles each present their own address and cycle type on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the sequencer |
| load_n | input | 1 | Low: load a new base and cycle type; high: advance |
| addr_in | input | ADDR_W | External base address, taken on a load |
| sel | input | 1 | Selected (1) or deselect (0) cycle, taken on a load |
| wr | input | 1 | Write (1) or read (0), taken on a selected load |
| ilv_mode | input | 1 | Burst order for the next load: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current access address |
| cyc_out | output | 2 | Current cycle type: 00 deselect, 01 read, 10 write |
| loaded | output | 1 | 1 when the current cycle came from a load, 0 after an advance |

## Verification
The bench targets the wrap after the fourth advance in both orders, starting from odd and non-zero low bits. A design that carries into the upper bits, or saturates the counter, shows a wrong fifth address. It toggles the mode input in the middle of a burst. A design that reads the mode live instead of capturing it switches order partway through the burst. It sends advances after a deselect load and a load while the clock enable is high. Designs that resume counting, or that take the frozen input, move the address or the cycle type. Back-to-back loads and constrained-random mixes catch a load flag or a counter that is not cleared on every load.

// File: rtl/bas_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: cycle type codes are visible at the top-level port as 2 bits.
package bas_pkg;
    typedef enum logic [1:0] {
        CYC_DESEL = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10
    } cyc_e;
endpackage

// File: rtl/bas_base_reg.sv
// Module: bas_base_reg
// Holds the burst base address, the cycle type and the burst order captured
// on a load. Assumes cap is already qualified by the clock enable.
module bas_base_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              sel,
    input  logic              wr,
    input  logic              ilv_in,
    output logic [ADDR_W-1:0] base_q,
    output cyc_e              cyc_q,
    output logic              ilv_q
);

    cyc_e cyc_d;

    // Decode the cycle type presented with a load.
    always_comb begin
        if (!sel)     cyc_d = CYC_DESEL;
        else if (wr)  cyc_d = CYC_WRITE;
        else          cyc_d = CYC_READ;
    end

    // Capture base, type and order on a load; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cyc_q  <= CYC_DESEL;
            ilv_q  <= 1'b0;
        end else if (cap) begin
            base_q <= addr_in;
            cyc_q  <= cyc_d;
            ilv_q  <= ilv_in;
        end
    end

    AST_CAP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> base_q == $past(addr_in));                                   // R1
    AST_DESEL_ON_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !sel) |=> cyc_q == CYC_DESEL);                               // R1

endmodule

// File: rtl/bas_burst_cnt.sv
// Module: bas_burst_cnt
// Burst counter of CNT_W bits. It clears on a load and steps on an allowed
// advance. Wrapping is the natural overflow of the counter width.
// Assumes clr and step are never both high.
module bas_burst_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clear on load, step on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + ONE;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);                                                // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> cnt_q == $past(cnt_q) + ONE);                     // R2

endmodule

// File: rtl/bas_order.sv
// Module: bas_order
// Maps the base low bits and the burst count to the low address bits, in
// linear (modulo add) or interleaved (XOR) order. Purely combinational.
module bas_order #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base_lo,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ilv,
    output logic [CNT_W-1:0] lo_out
);

    // Select interleaved or linear order for the low bits.
    always_comb begin
        if (ilv) lo_out = base_lo ^ cnt;
        else     lo_out = base_lo + cnt;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Address sequencer for a synchronous memory port. A load (load_n low) takes
// a base address, a cycle type and a burst order. An advance (load_n high)
// steps a CNT_W-bit counter over the low address bits. An advance is ignored
// while deselected. clk_en_n high freezes all state.
// Assumes all inputs are synchronous to clk. rst_n is synchronous, active low.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              sel,
    input  logic              wr,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        cyc_out,
    output logic              loaded
);

    localparam int HI_W = ADDR_W - CNT_W;

    logic              en;
    logic              cap;
    logic              step;
    logic [ADDR_W-1:0] base_q;
    cyc_e              cyc_q;
    logic              ilv_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lo;
    logic              loaded_q;

    // Qualify load and advance with the clock enable and the select state.
    always_comb begin
        en   = !clk_en_n;
        cap  = en && !load_n;
        step = en && load_n && (cyc_q != CYC_DESEL);
    end

    bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .addr_in (addr_in),
        .sel     (sel),
        .wr      (wr),
        .ilv_in  (ilv_mode),
        .base_q  (base_q),
        .cyc_q   (cyc_q),
        .ilv_q   (ilv_q)
    );

    bas_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap),
        .step  (step),
        .cnt_q (cnt_q)
    );

    bas_order #(.CNT_W(CNT_W)) u_order (
        .base_lo (base_q[CNT_W-1:0]),
        .cnt     (cnt_q),
        .ilv     (ilv_q),
        .lo_out  (lo)
    );

    // Record whether the latest enabled cycle was a load or an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   loaded_q <= 1'b0;
        else if (en)  loaded_q <= !load_n;
    end

    // Drive the outputs from the registered state.
    always_comb begin
        addr_out = {base_q[ADDR_W-1:CNT_W], lo};
        cyc_out  = cyc_q;
        loaded   = loaded_q;
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> (addr_out == $past(addr_in)) && loaded);  // R1
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> $stable(addr_out[ADDR_W-1:CNT_W])
                                  && $stable(cyc_out) && !loaded);           // R2
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(addr_out) && $stable(cyc_out)
                     && $stable(loaded));                                    // R7
    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && cyc_out == 2'b00) |=>
            (cyc_out == 2'b00) && $stable(addr_out));                        // R8
    AST_CYC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_out != 2'b11);                                                   // R1
    AST_HI_W_OK: assert final (HI_W >= 0);                                   // R2

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic          load_n;
    logic [AW-1:0] addr_in;
    logic          sel;
    logic          wr;
    logic          ilv_mode;
    logic [AW-1:0] addr_out;
    logic [1:0]    cyc_out;
    logic          loaded;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic [1:0]    m_cyc;
    logic          m_ilv;
    logic          m_ld;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .addr_in(addr_in), .sel(sel), .wr(wr), .ilv_mode(ilv_mode),
        .addr_out(addr_out), .cyc_out(cyc_out), .loaded(loaded)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [1:0] cyc_code(input logic s, input logic w);
        if (!s) return 2'b00;
        return w ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input string tag);
        logic [AW+2:0] act;
        logic [AW+2:0] exp;
        act = {addr_out, cyc_out, loaded};
        exp = {exp_addr(), m_cyc, m_ld};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: addr/cyc/loaded actual %h/%b/%b expected %h/%b/%b",
                     tag, addr_out, cyc_out, loaded, exp_addr(), m_cyc, m_ld);
        end
    endtask

    task automatic step(input logic en_n, input logic ld_n, input logic [AW-1:0] a,
                        input logic s, input logic w, input logic m, input string tag);
        clk_en_n = en_n; load_n = ld_n; addr_in = a; sel = s; wr = w; ilv_mode = m;
        @(posedge clk);
        if (!en_n) begin
            if (!ld_n) begin
                m_base = a; m_cnt = 2'd0; m_cyc = cyc_code(s, w); m_ilv = m; m_ld = 1'b1;
            end else begin
                if (m_cyc != 2'b00) m_cnt = m_cnt + 2'd1;
                m_ld = 1'b0;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_base = '0; m_cnt = '0; m_cyc = 2'b00; m_ilv = 1'b0; m_ld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        clk_en_n = 1'b0; load_n = 1'b1; addr_in = '0; sel = 1'b0; wr = 1'b0; ilv_mode = 1'b0;
        do_reset();
        check("R9");

        // R3/R5: linear burst from low bits 2: 2,3,0,1 then back to 2
        step(1'b0, 1'b0, 18'h12A76, 1'b1, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R5");
        if (addr_out !== 18'h12A76) begin
            n_fail++; $display("FAIL R5: actual %h expected %h", addr_out, 18'h12A76);
        end
        n_chk++;

        // R4/R6: interleaved from low bits 1: 1,0,3,2, mode toggled mid-burst
        step(1'b0, 1'b0, 18'h3FFF1, 1'b1, 1'b1, 1'b1, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, 1'b0, 1'b0, i[0], "R6");
        step(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R5");

        // linear from low bits 3 with the mode held high during advances
        step(1'b0, 1'b0, 18'h00003, 1'b1, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, '0, 1'b1, 1'b0, 1'b1, "R6");

        // R7: freeze with a pending load and then an advance
        step(1'b0, 1'b0, 18'h20005, 1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 18'h1ABCD, 1'b0, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b1, 18'h00000, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, '0, 1'b1, 1'b0, 1'b0, "R2");

        // R8: deselect load then advances
        step(1'b0, 1'b0, 18'h15556, 1'b0, 1'b1, 1'b1, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R8");

        // R10: back-to-back loads
        step(1'b0, 1'b0, 18'h0A001, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 18'h0B002, 1'b1, 1'b1, 1'b1, "R10");
        step(1'b0, 1'b0, 18'h0C003, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 18'h0D000, 1'b1, 1'b0, 1'b1, "R10");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic en_n, ld_n, s, w, m;
            logic [AW-1:0] a;
            string tag;
            en_n = ($urandom % 8) == 0;
            ld_n = ($urandom % 3) != 0;
            s    = ($urandom % 5) != 0;
            w    = $urandom % 2;
            m    = $urandom % 2;
            a    = AW'($urandom);
            if (en_n)              tag = "R7";
            else if (!ld_n)        tag = "R1";
            else if (m_cyc == 2'b00) tag = "R8";
            else if (m_ilv)        tag = "R4";
            else                   tag = "R3";
            step(en_n, ld_n, a, s, w, m, tag);
        end

        // R9: reset in the middle of a burst
        step(1'b0, 1'b0, 18'h2FFFE, 1'b1, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R2");
        do_reset();
        check("R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule